// File: doc/BRIEF.md
# Banked Dual Data Pointer Unit

This block sits in the special-function-register space of an 8-bit microcontroller core. It holds two 16-bit pointers into external data memory and a small control register. A select bit in that control register decides which pointer the core can see. Both pointers share a single pair of SFR byte addresses. Reads and writes at that pair, and the increment strobe, act only on the pointer that is selected. The other pointer keeps its value.

The selected pointer drives the address for external data memory accesses. Software switches between two address streams by changing one bit, and does not need to save or restore a pointer. Bit 2 of the control register is wired to zero. The core can therefore increment the whole control register in a read-modify-write to flip the select bit. The user flag in bit 3 is not disturbed, because the carry out of bit 0 stops in bit 1, which is not stored, and never reaches bit 3.

Top module: `dptr_unit`

## Requirements
- R1: After reset both pointers hold 0x0000, the select bit is 0 and the user flag is 0, so the control register reads 0x00 and `xmem_addr` is 0x0000.
- R2: SFR address 0x82 accesses the low byte and 0x83 the high byte of the selected pointer. A write takes effect at the clock edge that samples `sfr_wr`. Reads are combinational.
- R3: The control register is at SFR address 0xA2. Bit 0 is the select bit: 0 selects pointer 0 and 1 selects pointer 1. Bit 3 is a user flag that can be read and written.
- R4: Control register bits 7..4, bit 2 and bit 1 always read 0, and writes to them are ignored.
- R5: Reading the control register, adding 1 and writing the result back toggles bit 0 and leaves bit 3 unchanged.
- R6: The pointer that is not selected keeps its value while the selected pointer is written or incremented.
- R7: An `ptr_inc` pulse adds 1 to the whole selected 16-bit pointer. The carry passes from the low byte into the high byte, and 0xFFFF wraps to 0x0000.
- R8: `xmem_addr` always equals the selected pointer.
- R9: When a control register write and `ptr_inc` occur in the same cycle, the increment goes to the pointer that was selected before the write.
- R10: When a pointer byte write and `ptr_inc` occur in the same cycle, the write takes effect and no increment happens.
- R11: A read of any SFR address other than 0x82, 0x83 or 0xA2 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Combinational SFR read data |
| ptr_inc | input | 1 | Increment the selected pointer |
| xmem_addr | output | 16 | External data memory address, taken from the selected pointer |

## Verification
The increment path is exercised with a plain low-byte step, with a low byte of 0xFF so that the carry must reach the high byte, and with 0xFFFF so that the pointer must wrap. These three cases separate a full 16-bit adder from one that works on a byte, or one that saturates. Writes and increments are placed in the same cycle as a control register write and as a pointer byte write. These cases show which select value and which source win when two updates collide. The read-increment-write sequence on the control register is run with the flag set and the select bit both clear and set. This shows that the carry is stopped before the flag.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2 * BYTE_W;
  localparam int NPTR   = 2;
  localparam int SEL_W  = $clog2(NPTR);

  // control register bit positions (fixed: the increment-to-toggle trick depends on them)
  localparam int SEL_BIT  = 0;
  localparam int ZERO_BIT = 2;
  localparam int FLAG_BIT = 3;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_LO   = 2'd1,
    RD_HI   = 2'd2,
    RD_AUX  = 2'd3
  } rd_src_e;

  // next pointer value: a byte write beats the increment
  function automatic logic [PTR_W-1:0] ptr_next(
    input logic [PTR_W-1:0]  cur,
    input logic              inc,
    input logic              wr_lo,
    input logic              wr_hi,
    input logic [BYTE_W-1:0] wdata
  );
    logic [PTR_W-1:0] nxt;
    nxt = cur;
    if (wr_lo || wr_hi) begin
      if (wr_lo) nxt[BYTE_W-1:0]     = wdata;
      if (wr_hi) nxt[PTR_W-1:BYTE_W] = wdata;
    end else if (inc) begin
      nxt = cur + {{(PTR_W-1){1'b0}}, 1'b1};
    end
    return nxt;
  endfunction

  // visible image of the control register; unstored bits read 0
  function automatic logic [BYTE_W-1:0] aux_image(
    input logic sel,
    input logic flag
  );
    logic [BYTE_W-1:0] img;
    img = '0;
    img[SEL_BIT]  = sel;
    img[FLAG_BIT] = flag;
    return img;
  endfunction
endpackage

// File: rtl/dptr_decode.sv
module dptr_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_LO  = 8'h82,
  parameter logic [ADDR_W-1:0] A_HI  = 8'h83,
  parameter logic [ADDR_W-1:0] A_AUX = 8'hA2
) (
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              wr_aux,
  output dptr_pkg::rd_src_e rd_src
);
  import dptr_pkg::*;

  always_comb begin
    rd_src = RD_NONE;
    if (sfr_addr == A_LO)       rd_src = RD_LO;
    else if (sfr_addr == A_HI)  rd_src = RD_HI;
    else if (sfr_addr == A_AUX) rd_src = RD_AUX;
  end

  assign wr_lo  = sfr_wr && (rd_src == RD_LO);
  assign wr_hi  = sfr_wr && (rd_src == RD_HI);
  assign wr_aux = sfr_wr && (rd_src == RD_AUX);
endmodule

// File: rtl/dptr_aux_reg.sv
module dptr_aux_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_aux,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel_q,
  output logic              flag_q
);
  import dptr_pkg::*;

  // only two bits are stored; every other bit is a constant zero on read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (wr_aux) begin
      sel_q  <= wdata[SEL_BIT];
      flag_q <= wdata[FLAG_BIT];
    end
  end
endmodule

// File: rtl/dptr_cell.sv
module dptr_cell #(
  parameter int PW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_lo,
  input  logic          en_hi,
  input  logic          en_inc,
  input  logic [BW-1:0] wdata,
  output logic [PW-1:0] ptr_q
);
  import dptr_pkg::*;

  logic [PW-1:0] ptr_d;

  always_comb ptr_d = ptr_next(ptr_q, en_inc, en_lo, en_hi, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/dptr_unit.sv
module dptr_unit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = dptr_pkg::BYTE_W,
  parameter int PTR_W  = dptr_pkg::PTR_W,
  parameter logic [ADDR_W-1:0] A_LO  = 8'h82,
  parameter logic [ADDR_W-1:0] A_HI  = 8'h83,
  parameter logic [ADDR_W-1:0] A_AUX = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic              ptr_inc,
  output logic [PTR_W-1:0]  xmem_addr
);
  import dptr_pkg::*;

  localparam int NP = NPTR;

  logic              wr_lo, wr_hi, wr_aux;
  rd_src_e           rd_src;
  logic              sel_q, flag_q;
  logic [PTR_W-1:0]  ptr_q [NP];
  logic [PTR_W-1:0]  cur_ptr;
  logic [NP-1:0]     hit;

  dptr_decode #(.ADDR_W(ADDR_W), .A_LO(A_LO), .A_HI(A_HI), .A_AUX(A_AUX)) u_dec (
    .sfr_wr   (sfr_wr),
    .sfr_addr (sfr_addr),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_aux   (wr_aux),
    .rd_src   (rd_src)
  );

  dptr_aux_reg #(.DATA_W(DATA_W)) u_aux (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_aux (wr_aux),
    .wdata  (sfr_wdata),
    .sel_q  (sel_q),
    .flag_q (flag_q)
  );

  // pointer bank: the select value held this cycle routes all pointer events
  for (genvar i = 0; i < NP; i++) begin : g_ptr
    assign hit[i] = (sel_q == i[0]);
    dptr_cell #(.PW(PTR_W), .BW(DATA_W)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_lo  (wr_lo && hit[i]),
      .en_hi  (wr_hi && hit[i]),
      .en_inc (ptr_inc && hit[i]),
      .wdata  (sfr_wdata),
      .ptr_q  (ptr_q[i])
    );
  end

  assign cur_ptr   = ptr_q[sel_q];
  assign xmem_addr = cur_ptr;

  always_comb begin
    unique case (rd_src)
      RD_LO:   sfr_rdata = cur_ptr[DATA_W-1:0];
      RD_HI:   sfr_rdata = cur_ptr[PTR_W-1:DATA_W];
      RD_AUX:  sfr_rdata = aux_image(sel_q, flag_q);
      default: sfr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dptr_unit_chk.sv
module dptr_unit_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 16,
  parameter logic [ADDR_W-1:0] A_AUX = 8'hA2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sfr_addr,
  input logic [DATA_W-1:0] sfr_wdata,
  input logic [DATA_W-1:0] sfr_rdata,
  input logic              ptr_inc,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic              wr_aux,
  input logic              sel_q,
  input logic              flag_q,
  input logic [PTR_W-1:0]  ptr0,
  input logic [PTR_W-1:0]  ptr1,
  input logic [PTR_W-1:0]  xmem_addr
);
  AST_PTR0_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |=> $stable(ptr0)); // R6
  AST_PTR1_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |=> $stable(ptr1)); // R6
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !wr_lo && !wr_hi && !sel_q) |=> ptr0 == $past(ptr0) + 16'd1); // R7
  AST_WRITE_BEATS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi && !sel_q) |=> ptr0[15:8] == $past(ptr0[15:8])); // R10
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_aux |=> sel_q == $past(sfr_wdata[0])); // R3
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_aux |=> $stable(flag_q)); // R3
  AST_AUX_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == A_AUX) |-> (sfr_rdata[7:4] == 4'd0 && sfr_rdata[2:1] == 2'd0)); // R4
  AST_XADDR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    xmem_addr == (sel_q ? ptr1 : ptr0)); // R8
endmodule

bind dptr_unit dptr_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .A_AUX(A_AUX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sfr_addr  (sfr_addr),
  .sfr_wdata (sfr_wdata),
  .sfr_rdata (sfr_rdata),
  .ptr_inc   (ptr_inc),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .wr_aux    (wr_aux),
  .sel_q     (sel_q),
  .flag_q    (flag_q),
  .ptr0      (ptr_q[0]),
  .ptr1      (ptr_q[1]),
  .xmem_addr (xmem_addr)
);

// File: tb/sim_dptr_unit.sv
module sim_dptr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        ptr_inc = 1'b0;
  logic [15:0] xmem_addr;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ptr_inc(ptr_inc),
    .xmem_addr(xmem_addr)
  );

  // {wr, waddr, wdata, inc, raddr, expected}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 8'h82, 8'h34, 1'b0, 8'h82, 8'h34}, // R2 low byte of pointer 0
    {1'b1, 8'h83, 8'h12, 1'b0, 8'h83, 8'h12}, // R2 high byte
    {1'b0, 8'h00, 8'h00, 1'b1, 8'h82, 8'h35}, // R7 plain step
    {1'b1, 8'hA2, 8'h01, 1'b0, 8'h82, 8'h00}, // R3 select pointer 1
    {1'b1, 8'h82, 8'hFF, 1'b0, 8'h82, 8'hFF}, // R2
    {1'b1, 8'h83, 8'hFF, 1'b0, 8'h83, 8'hFF}, // R2
    {1'b0, 8'h00, 8'h00, 1'b1, 8'h82, 8'h00}, // R7 wrap low
    {1'b0, 8'h00, 8'h00, 1'b0, 8'h83, 8'h00}, // R7 wrap high
    {1'b1, 8'hA2, 8'h00, 1'b0, 8'h82, 8'h35}, // R6 pointer 0 untouched
    {1'b1, 8'hA2, 8'hFF, 1'b0, 8'hA2, 8'h09}, // R4 unstored bits read 0
    {1'b1, 8'hA2, 8'h00, 1'b1, 8'h82, 8'h35}, // R9 inc goes to old pointer 1
    {1'b1, 8'hA2, 8'h01, 1'b0, 8'h82, 8'h01}, // R9 pointer 1 got it
    {1'b1, 8'h82, 8'h50, 1'b1, 8'h82, 8'h50}, // R10 write wins
    {1'b0, 8'h00, 8'h00, 1'b0, 8'h83, 8'h00}, // R10 no increment
    {1'b1, 8'h82, 8'hFF, 1'b0, 8'h82, 8'hFF}, // R2
    {1'b0, 8'h00, 8'h00, 1'b1, 8'h83, 8'h01}, // R7 carry into high byte
    {1'b0, 8'h00, 8'h00, 1'b0, 8'h90, 8'h00}  // R11 foreign address
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfr_wr = 1'b0; ptr_inc = 1'b0; sfr_addr = a;
    #1 d = sfr_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic inc);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d; ptr_inc = inc;
    @(negedge clk);
    sfr_wr = 1'b0; ptr_inc = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 xmem", xmem_addr, 16'h0000);
    rd(8'hA2, v); check("R1 aux", {8'h00, v}, 16'h0000);
    rd(8'h82, v); check("R1 lo", {8'h00, v}, 16'h0000);
    rd(8'h83, v); check("R1 hi", {8'h00, v}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      sfr_wr = VEC[i][33]; sfr_addr = VEC[i][32:25];
      sfr_wdata = VEC[i][24:17]; ptr_inc = VEC[i][16];
      rd(VEC[i][15:8], v);
      check($sformatf("vector %0d", i), {8'h00, v}, {8'h00, VEC[i][7:0]});
    end

    // R8: pointer 1 selected and holds 0x0100
    check("R8 xmem sel1", xmem_addr, 16'h0100);

    // R5: increment-to-toggle keeps the flag
    wr(8'hA2, 8'h08, 1'b0);
    check("R8 xmem sel0", xmem_addr, 16'h1235);
    rd(8'hA2, v); wr(8'hA2, v + 8'd1, 1'b0);
    rd(8'hA2, v); check("R5 toggle to 1", {8'h00, v}, 16'h0009);
    wr(8'hA2, v + 8'd1, 1'b0);
    rd(8'hA2, v); check("R5 toggle to 0", {8'h00, v}, 16'h0008);
    check("R5 xmem back on pointer 0", xmem_addr, 16'h1235);

    // R1 reset in mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 xmem after reset", xmem_addr, 16'h0000);
    rd(8'hA2, v); check("R1 aux after reset", {8'h00, v}, 16'h0000);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule